// File: doc/BRIEF.md
# PIO Sliding Window Address Remapper

This block sits between a bus-slave decoder and a local memory. It turns the offset of a programmed I/O access into a local memory address through a window that can be slid over the installed memory. The window size comes from two strap pins. A two-bit code gives the installed memory size. Together they set how many aligned windows exist. The window can cover the whole memory, 64 MB, 16 MB or 2 MB. The memory can be 64, 128 or 256 MB.

Software sees three registers through a small register port. The first is a read-only range register, which holds the address mask of the window. The second is a writable remap register, which selects the window base. The third is a read-only status word that reports the captured straps and memory code. Bits of the remap register that lie below the window size, or above the installed memory, cannot be set. So the remap register can only point at an aligned window that exists. Each access is translated in one clock cycle. The straps and memory code are sampled once after reset and are then held.

Top module: `pio_window_remap`

## Requirements
- R1: The range register (register address 0) reads 0xFFFFFFFF shifted left by the window log2 size. The window is chosen by the captured straps as {strap_b, strap_a}: 00 gives the full installed memory, 01 gives 64 MB (log2 26), 10 gives 16 MB (log2 24) and 11 gives 2 MB (log2 21).
- R2: The memory code sets the installed memory as follows: 00 is 64 MB (log2 26), 01 is 128 MB (log2 27), 10 is 256 MB (log2 28), and 11 is also 256 MB. This size sets the full-memory window and the upper bound of the remap register.
- R3: After reset, the remap register (register address 1) reads 0x00000001.
- R4: A write to the remap register stores only the bits at or above the window log2 size and below the installed memory log2 size. All other bits read 0, except bit 0, which always reads 1. Every aligned window in the memory, memory/window of them, can be selected.
- R5: Writes to the range register, the status register and the unused address 3 have no effect. Address 3 reads 0.
- R6: An access with acc_valid_i high produces lcl_valid_o high one cycle later. In that cycle lcl_addr_o equals ((offset AND NOT range) OR (remap AND range)) AND (installed size - 1). It uses the remap value from before any write made in the same cycle. lcl_valid_o is low in cycles after no access.
- R7: The straps and memory code are captured on the first clock edge after the internal reset is released. Later changes to these inputs have no effect until the next reset.
- R8: The status register (register address 2) reads strap_a in bit 19, the memory code in bits 21:20 and strap_b in bit 22. All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_a_i | input | 1 | Window-size strap A (low bit of the select) |
| strap_b_i | input | 1 | Window-size strap B (high bit of the select) |
| mem_code_i | input | 2 | Installed memory size code |
| reg_addr_i | input | 2 | Register address: 0 range, 1 remap, 2 status, 3 unused |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| acc_valid_i | input | 1 | Access offset is valid this cycle |
| acc_offset_i | input | 32 | Access offset within the bus window |
| lcl_valid_o | output | 1 | Translated address is valid |
| lcl_addr_o | output | 32 | Translated local memory address |

## Verification
The assertions check several properties on every cycle. Bit 0 of the remap register stays set, and the remap register never holds a bit outside its writable span. Every access yields a valid translation one cycle later, with the address formed from the previous offset, remap and masks. The range readback stays constant once the configuration is captured. The remap register also holds its reset value when capture happens. Only the bench's scenarios can show the parts that depend on the configuration. These are the mapping of each strap and memory code to the exact masks and status fields, the reachability of every aligned window, the lack of effect of strap changes after capture, and a new capture after a second reset. The bench therefore sweeps all sixteen strap and size combinations and walks through every window of each one.

// File: rtl/pio_win_pkg.sv
package pio_win_pkg;

  // Window select as {strap_b, strap_a}
  typedef enum logic [1:0] {
    WSEL_FULL  = 2'b00,
    WSEL_LARGE = 2'b01,
    WSEL_MID   = 2'b10,
    WSEL_SMALL = 2'b11
  } win_sel_e;

  // Register port addresses
  typedef enum logic [1:0] {
    RA_RANGE  = 2'd0,
    RA_REMAP  = 2'd1,
    RA_STATUS = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;

  // Captured hardware configuration
  typedef struct packed {
    logic       strap_b;
    logic       strap_a;
    logic [1:0] mem_code;
  } hw_cfg_t;

  // Status word field positions
  localparam int STAT_STRAP_A_BIT = 19;
  localparam int STAT_MEM_LO_BIT  = 20;
  localparam int STAT_STRAP_B_BIT = 22;

endpackage

// File: rtl/pio_win_rst_sync.sv
module pio_win_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pio_win_cfg.sv
module pio_win_cfg
  import pio_win_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int LOG_W          = 6,
  parameter int MEM_BASE_LOG2  = 26,
  parameter int WIN_LARGE_LOG2 = 26,
  parameter int WIN_MID_LOG2   = 24,
  parameter int WIN_SMALL_LOG2 = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hw_cfg_t           cfg_i,
  output hw_cfg_t           cfg_o,
  output logic              init_o,
  output logic [ADDR_W-1:0] range_mask_o,
  output logic [ADDR_W-1:0] mem_mask_o,
  output logic [ADDR_W-1:0] wr_mask_o
);

  localparam logic [LOG_W-1:0] MEM_L0 = LOG_W'(MEM_BASE_LOG2);
  localparam logic [LOG_W-1:0] MEM_L1 = LOG_W'(MEM_BASE_LOG2 + 1);
  localparam logic [LOG_W-1:0] MEM_L2 = LOG_W'(MEM_BASE_LOG2 + 2);

  hw_cfg_t          cfg_q, cfg_d;
  logic             init_q, init_d;
  logic             cfg_en;
  win_sel_e         win_sel;
  logic [LOG_W-1:0] win_log2;
  logic [LOG_W-1:0] mem_log2;

  // Capture enable: open only until the first edge after reset release
  always_comb begin
    cfg_en = !init_q;
    cfg_d  = cfg_i;
    init_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      init_q <= 1'b0;
    end else begin
      if (cfg_en) begin
        cfg_q <= cfg_d;
      end
      init_q <= init_d;
    end
  end

  // Installed memory size; code 3 aliases the largest size
  always_comb begin
    unique case (cfg_q.mem_code)
      2'd0:    mem_log2 = MEM_L0;
      2'd1:    mem_log2 = MEM_L1;
      default: mem_log2 = MEM_L2;
    endcase
  end

  always_comb begin
    win_sel = win_sel_e'({cfg_q.strap_b, cfg_q.strap_a});
    unique case (win_sel)
      WSEL_LARGE: win_log2 = LOG_W'(WIN_LARGE_LOG2);
      WSEL_MID:   win_log2 = LOG_W'(WIN_MID_LOG2);
      WSEL_SMALL: win_log2 = LOG_W'(WIN_SMALL_LOG2);
      default:    win_log2 = mem_log2;
    endcase
  end

  // Per-bit mask generation
  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_mask
    assign range_mask_o[gi] = (LOG_W'(gi) >= win_log2);
    assign mem_mask_o[gi]   = (LOG_W'(gi) <  mem_log2);
    assign wr_mask_o[gi]    = range_mask_o[gi] & mem_mask_o[gi];
  end

  assign cfg_o  = cfg_q;
  assign init_o = init_q;

endmodule

// File: rtl/pio_win_regs.sv
module pio_win_regs
  import pio_win_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  hw_cfg_t           cfg_i,
  input  logic [ADDR_W-1:0] range_mask_i,
  input  logic [ADDR_W-1:0] wr_mask_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic [ADDR_W-1:0] remap_o
);

  localparam logic [ADDR_W-1:0] REMAP_RST = ADDR_W'(1);

  logic [ADDR_W-1:0] remap_q, remap_d;
  logic              remap_en;
  logic [ADDR_W-1:0] status_w;
  reg_addr_e         addr_e;

  always_comb begin
    addr_e   = reg_addr_e'(reg_addr_i);
    remap_en = init_i && reg_we_i && (addr_e == RA_REMAP);
    remap_d  = (reg_wdata_i & wr_mask_i) | REMAP_RST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_q <= REMAP_RST;
    end else if (remap_en) begin
      remap_q <= remap_d;
    end
  end

  always_comb begin
    status_w = '0;
    status_w[STAT_STRAP_A_BIT]                    = cfg_i.strap_a;
    status_w[STAT_STRAP_B_BIT]                    = cfg_i.strap_b;
    status_w[STAT_MEM_LO_BIT+1:STAT_MEM_LO_BIT]   = cfg_i.mem_code;
  end

  always_comb begin
    unique case (addr_e)
      RA_RANGE:  reg_rdata_o = range_mask_i;
      RA_REMAP:  reg_rdata_o = remap_q;
      RA_STATUS: reg_rdata_o = status_w;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign remap_o = remap_q;

endmodule

// File: rtl/pio_win_xlate.sv
module pio_win_xlate #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] range_mask_i,
  input  logic [ADDR_W-1:0] mem_mask_i,
  input  logic [ADDR_W-1:0] remap_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_offset_i,
  output logic              lcl_valid_o,
  output logic [ADDR_W-1:0] lcl_addr_o
);

  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    valid_d = acc_valid_i;
    addr_en = acc_valid_i;
    addr_d  = ((acc_offset_i & ~range_mask_i) | (remap_i & range_mask_i))
              & mem_mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (addr_en) begin
        addr_q <= addr_d;
      end
    end
  end

  assign lcl_valid_o = valid_q;
  assign lcl_addr_o  = addr_q;

endmodule

// File: rtl/pio_window_remap.sv
module pio_window_remap
  import pio_win_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int MEM_BASE_LOG2  = 26,
  parameter int WIN_LARGE_LOG2 = 26,
  parameter int WIN_MID_LOG2   = 24,
  parameter int WIN_SMALL_LOG2 = 21,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_a_i,
  input  logic              strap_b_i,
  input  logic [1:0]        mem_code_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_offset_i,
  output logic              lcl_valid_o,
  output logic [ADDR_W-1:0] lcl_addr_o
);

  localparam int LOG_W = $clog2(ADDR_W + 1);

  logic              rst_sync_n;
  hw_cfg_t           cfg_in, cfg_cur;
  logic              init_w;
  logic [ADDR_W-1:0] range_mask, mem_mask, wr_mask, remap_w;

  assign cfg_in = '{strap_b: strap_b_i, strap_a: strap_a_i, mem_code: mem_code_i};

  pio_win_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pio_win_cfg #(
    .ADDR_W        (ADDR_W),
    .LOG_W         (LOG_W),
    .MEM_BASE_LOG2 (MEM_BASE_LOG2),
    .WIN_LARGE_LOG2(WIN_LARGE_LOG2),
    .WIN_MID_LOG2  (WIN_MID_LOG2),
    .WIN_SMALL_LOG2(WIN_SMALL_LOG2)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cfg_i        (cfg_in),
    .cfg_o        (cfg_cur),
    .init_o       (init_w),
    .range_mask_o (range_mask),
    .mem_mask_o   (mem_mask),
    .wr_mask_o    (wr_mask)
  );

  pio_win_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .init_i       (init_w),
    .cfg_i        (cfg_cur),
    .range_mask_i (range_mask),
    .wr_mask_i    (wr_mask),
    .reg_addr_i   (reg_addr_i),
    .reg_we_i     (reg_we_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .remap_o      (remap_w)
  );

  pio_win_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .range_mask_i (range_mask),
    .mem_mask_i   (mem_mask),
    .remap_i      (remap_w),
    .acc_valid_i  (acc_valid_i),
    .acc_offset_i (acc_offset_i),
    .lcl_valid_o  (lcl_valid_o),
    .lcl_addr_o   (lcl_addr_o)
  );

endmodule

// File: rtl/pio_window_remap_chk.sv
module pio_window_remap_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_w,
  input logic [ADDR_W-1:0] remap_w,
  input logic [ADDR_W-1:0] wr_mask,
  input logic [ADDR_W-1:0] range_mask,
  input logic [ADDR_W-1:0] mem_mask,
  input logic [1:0]        reg_addr_i,
  input logic [ADDR_W-1:0] reg_rdata_o,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_offset_i,
  input logic              lcl_valid_o,
  input logic [ADDR_W-1:0] lcl_addr_o
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // R4
  remap_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remap_w[0] == 1'b1);

  // R4
  remap_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_w & ~(wr_mask | ONE)) == '0);

  // R3
  remap_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_w) |-> remap_w == ONE);

  // R6
  lcl_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i |=> lcl_valid_o);

  // R6
  lcl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> !lcl_valid_o);

  // R6
  lcl_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i |=> lcl_addr_o ==
      ((($past(acc_offset_i) & ~$past(range_mask)) |
        ($past(remap_w) & $past(range_mask))) & $past(mem_mask)));

  // R7
  range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_w && $past(init_w) && reg_addr_i == 2'd0 && $past(reg_addr_i) == 2'd0)
      |-> $stable(reg_rdata_o));

endmodule

bind pio_window_remap pio_window_remap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .init_w       (init_w),
  .remap_w      (remap_w),
  .wr_mask      (wr_mask),
  .range_mask   (range_mask),
  .mem_mask     (mem_mask),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .acc_valid_i  (acc_valid_i),
  .acc_offset_i (acc_offset_i),
  .lcl_valid_o  (lcl_valid_o),
  .lcl_addr_o   (lcl_addr_o)
);

// File: tb/pio_window_remap_tb.sv
module pio_window_remap_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        strap_a, strap_b;
  logic [1:0]  mem_code;
  logic [1:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        acc_valid;
  logic [31:0] acc_offset;
  logic        lcl_valid;
  logic [31:0] lcl_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  pio_window_remap u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_a_i    (strap_a),
    .strap_b_i    (strap_b),
    .mem_code_i   (mem_code),
    .reg_addr_i   (reg_addr),
    .reg_we_i     (reg_we),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .acc_valid_i  (acc_valid),
    .acc_offset_i (acc_offset),
    .lcl_valid_o  (lcl_valid),
    .lcl_addr_o   (lcl_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic a, input logic b, input logic [1:0] code);
    @(negedge clk);
    rst_n    = 1'b0;
    strap_a  = a;
    strap_b  = b;
    mem_code = code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] addr, input logic [31:0] data);
    reg_addr  = addr;
    reg_wdata = data;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] addr, output logic [31:0] data);
    reg_addr = addr;
    #1;
    data = reg_rdata;
  endtask

  task automatic access(input logic [31:0] off, output logic v, output logic [31:0] a);
    acc_offset = off;
    acc_valid  = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    v = lcl_valid;
    a = lcl_addr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv, la;
    logic        lv;
    rst_n = 1'b0; strap_a = 0; strap_b = 0; mem_code = 0;
    reg_addr = 0; reg_we = 0; reg_wdata = 0; acc_valid = 0; acc_offset = 0;

    for (int cfg = 0; cfg < 16; cfg++) begin
      logic        a, b;
      logic [1:0]  code;
      int          m, w, nwin;
      logic [31:0] rng, mmask, stat, exp_remap;
      a    = cfg[0];
      b    = cfg[1];
      code = cfg[3:2];
      m    = 26 + ((code > 2) ? 2 : int'(code));
      case ({b, a})
        2'b00:   w = m;
        2'b01:   w = 26;
        2'b10:   w = 24;
        default: w = 21;
      endcase
      rng   = 32'hFFFF_FFFF << w;
      mmask = (32'h1 << m) - 32'h1;
      stat  = (32'(b) << 22) | (32'(code) << 20) | (32'(a) << 19);
      nwin  = 1 << (m - w);

      do_reset(a, b, code);

      rd(2'd0, rv); chk("R1 R2 range", rv, rng);
      rd(2'd1, rv); chk("R3 remap reset", rv, 32'h1);
      rd(2'd2, rv); chk("R8 status", rv, stat);
      rd(2'd3, rv); chk("R5 unused reads 0", rv, 32'h0);
      chk("R6 idle valid", {31'b0, lcl_valid}, 32'h0);

      // every window reachable, illegal bits dropped
      for (int k = 0; k < nwin; k++) begin
        logic [31:0] off;
        wr(2'd1, (32'(k) << w) | 32'hF01F_FFFE);
        exp_remap = (32'(k) << w) | 32'h1;
        rd(2'd1, rv); chk("R4 remap window", rv, exp_remap);
        off = 32'hDEAD_BEEC ^ 32'(k * 32'h0001_1111);
        access(off, lv, la);
        chk("R6 valid", {31'b0, lv}, 32'h1);
        chk("R6 local addr", la, ((off & ~rng) | (exp_remap & rng)) & mmask);
        @(negedge clk);
        chk("R6 valid drops", {31'b0, lcl_valid}, 32'h0);
      end

      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, rv); chk("R4 all ones", rv, (rng & mmask) | 32'h1);
      wr(2'd1, 32'h0);
      rd(2'd1, rv); chk("R4 zero keeps bit0", rv, 32'h1);

      // read-only locations
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd0, 32'h0);
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd0, rv); chk("R5 range ignores write", rv, rng);
      rd(2'd2, rv); chk("R5 status ignores write", rv, stat);
      rd(2'd3, rv); chk("R5 unused ignores write", rv, 32'h0);
      rd(2'd1, rv); chk("R5 remap untouched", rv, (rng & mmask) | 32'h1);

      // same-cycle write and access uses the older remap
      acc_offset = 32'h0000_0004;
      acc_valid  = 1'b1;
      wr(2'd1, 32'h0);
      acc_valid  = 1'b0;
      chk("R6 old remap", lcl_addr, ((32'h4 & ~rng) | ((rng & mmask) | 32'h1) & rng) & mmask);

      // late strap change is ignored
      strap_a  = ~a;
      strap_b  = ~b;
      mem_code = ~code;
      repeat (3) @(negedge clk);
      rd(2'd0, rv); chk("R7 range held", rv, rng);
      rd(2'd2, rv); chk("R7 status held", rv, stat);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule